// File: doc/BRIEF.md
# Opcode Register Field Decoder

This block turns an instruction opcode into the select signals a register file needs. A 3-bit register code sits in one of two places in the opcode: the low position (bits 2:0) or the middle position (bits 5:3). A multiplexer picks one of these positions. The upper two bits of the picked code name a register pair, and the lowest bit names one byte of that pair.

The block has two special codes. Code 110 names no register. It stands for a memory operand reached through the HL pair, and the block reports it on its own output. In 16-bit pair mode only the two pair bits count, and pair code 11 can stand for the stack pointer in place of the AF pair. A separate input makes that choice, and an output reports which one was taken.

The logic is purely combinational. For a register-to-register move, the instruction sequencer presents the middle field (destination) and the low field (source) one after the other by toggling the position input.

Top module: `opfield_decoder`

## Requirements
- R1: With `field_pos` = 0 the decoded code is opcode bits 2:0. Opcode bits 7:3 have no effect on any output.
- R2: With `field_pos` = 1 the decoded code is opcode bits 5:3. Opcode bits 7:6 and 2:0 have no effect on any output.
- R3: In byte mode (`pair_mode` = 0), codes 000 through 101 set `pair_sel` to code bits 2:1 and `byte_hi` to the inverse of code bit 0, with `byte_valid` = 1 and `mem_hl` = 0. Pair encoding is 00 = BC, 01 = DE, 10 = HL, 11 = AF/SP. This maps 000 to B, 001 to C, 010 to D, 011 to E, 100 to H and 101 to L.
- R4: In byte mode, code 111 selects the accumulator: `pair_sel` = 11, `byte_hi` = 1, `byte_valid` = 1, `mem_hl` = 0.
- R5: In byte mode, code 110 gives `mem_hl` = 1, `pair_sel` = 10 (HL supplies the address), `byte_valid` = 0 and `byte_hi` = 0.
- R6: In pair mode, `pair_sel` equals code bits 2:1, and code bit 0 has no effect. `byte_valid`, `byte_hi` and `mem_hl` are all 0, including when the code is 110.
- R7: `sp_sub` is 1 exactly when pair mode is on, the pair code is 11 and `pair3_sp` = 1. In every other case `sp_sub` is 0, which means pair 11 is AF.
- R8: Outside pair mode, `pair3_sp` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 8 | Instruction opcode |
| field_pos | input | 1 | 0 = bits 2:0, 1 = bits 5:3 |
| pair_mode | input | 1 | 1 = 16-bit pair decoding |
| pair3_sp | input | 1 | In pair mode, pair code 11 means SP |
| pair_sel | output | 2 | Selected register pair |
| byte_hi | output | 1 | High byte of the pair selected |
| byte_valid | output | 1 | An 8-bit register is selected |
| mem_hl | output | 1 | Memory operand through HL |
| sp_sub | output | 1 | Pair 11 decoded as stack pointer |

## Verification
The bench builds the block with its default widths: an 8-bit opcode and a 3-bit field. These are the only values that match the pair/byte split. With them, every code in both field positions can be reached. The bench puts junk in the bits outside the selected field so that a wrong mux slice shows up. It also decodes every code in pair mode under both stack-pointer settings, and runs a move opcode through both of its fields.

// File: rtl/opfield_pkg.sv
// Shared encodings for the opcode register field decoder.
// Assumes a 3-bit register code and 2-bit pair code.
package opfield_pkg;
    localparam int FIELD_W = 3;
    localparam int PAIR_W  = FIELD_W - 1;

    // Register pair encoding on pair_sel
    localparam logic [PAIR_W-1:0] PAIR_BC  = 2'b00;
    localparam logic [PAIR_W-1:0] PAIR_DE  = 2'b01;
    localparam logic [PAIR_W-1:0] PAIR_HL  = 2'b10;
    localparam logic [PAIR_W-1:0] PAIR_TOP = 2'b11;

    // Special byte codes
    localparam logic [FIELD_W-1:0] CODE_MEM = 3'b110;
    localparam logic [FIELD_W-1:0] CODE_ACC = 3'b111;
endpackage

// File: rtl/opfield_mux.sv
// Picks one register field out of the opcode.
// Assumes field positions at bit 0 and bit FIELD_W, and OPC_W >= 2*FIELD_W.
module opfield_mux #(
    parameter int OPC_W   = 8,
    parameter int FIELD_W = 3
) (
    input  logic [OPC_W-1:0]   opcode,
    input  logic               field_pos,
    output logic [FIELD_W-1:0] code
);
    localparam int HI_BASE = FIELD_W;

    // Bits above both fields are read by no decoder
    logic unused_top;
    assign unused_top = ^opcode[OPC_W-1:2*FIELD_W];

    // Field position multiplexer
    always_comb begin
        if (field_pos) code = opcode[HI_BASE +: FIELD_W];
        else           code = opcode[0 +: FIELD_W];
    end
endmodule

// File: rtl/opfield_byte_dec.sv
// Decodes a register code as an 8-bit register or as a memory operand through HL.
// Assumes the code is known whenever outputs are checked.
module opfield_byte_dec
    import opfield_pkg::*;
(
    input  logic [FIELD_W-1:0] code,
    output logic [PAIR_W-1:0]  pair,
    output logic               hi,
    output logic               valid,
    output logic               mem
);
    // Pair/half split with the 110 and 111 exceptions
    always_comb begin
        pair  = code[FIELD_W-1:1];
        hi    = ~code[0];
        valid = 1'b1;
        mem   = 1'b0;
        if (code == CODE_MEM) begin
            pair  = PAIR_HL;
            hi    = 1'b0;
            valid = 1'b0;
            mem   = 1'b1;
        end else if (code == CODE_ACC) begin
            hi    = 1'b1;
        end
    end

    // A memory operand never also names a register, and HL supplies it (R5)
    always_comb begin
        if (!$isunknown(code)) begin
            assert_mem_excl_R5: assert (!(mem && valid));
            assert_mem_uses_hl_R5: assert (!mem || pair == PAIR_HL);
        end
    end
endmodule

// File: rtl/opfield_pair_dec.sv
// Decodes the two pair bits of a code in 16-bit mode, with the SP/AF choice for pair 11.
// Assumes code bit 0 is not part of a pair code.
module opfield_pair_dec
    import opfield_pkg::*;
(
    input  logic [FIELD_W-1:0] code,
    input  logic               top_is_sp,
    output logic [PAIR_W-1:0]  pair,
    output logic               sp
);
    logic unused_bit0;
    assign unused_bit0 = code[0];

    // Pair bits pass straight through; flag SP substitution
    always_comb begin
        pair = code[FIELD_W-1:1];
        sp   = top_is_sp && (code[FIELD_W-1:1] == PAIR_TOP);
    end
endmodule

// File: rtl/opfield_decoder.sv
// Top: opcode register field decoder.
// Selects a field position, then decodes either a byte register or a register pair.
// Purely combinational; assumes the caller holds inputs stable while sampling.
module opfield_decoder
    import opfield_pkg::*;
#(
    parameter int OPC_W = 8
) (
    input  logic [OPC_W-1:0]  opcode,
    input  logic              field_pos,
    input  logic              pair_mode,
    input  logic              pair3_sp,
    output logic [PAIR_W-1:0] pair_sel,
    output logic              byte_hi,
    output logic              byte_valid,
    output logic              mem_hl,
    output logic              sp_sub
);
    logic [FIELD_W-1:0] code;
    logic [PAIR_W-1:0]  b_pair, p_pair;
    logic               b_hi, b_valid, b_mem, p_sp;

    opfield_mux #(.OPC_W(OPC_W), .FIELD_W(FIELD_W)) u_mux (
        .opcode(opcode), .field_pos(field_pos), .code(code)
    );

    opfield_byte_dec u_byte (
        .code(code), .pair(b_pair), .hi(b_hi), .valid(b_valid), .mem(b_mem)
    );

    opfield_pair_dec u_pair (
        .code(code), .top_is_sp(pair3_sp), .pair(p_pair), .sp(p_sp)
    );

    // Output select between byte and pair decoding
    always_comb begin
        if (pair_mode) begin
            pair_sel   = p_pair;
            byte_hi    = 1'b0;
            byte_valid = 1'b0;
            mem_hl     = 1'b0;
            sp_sub     = p_sp;
        end else begin
            pair_sel   = b_pair;
            byte_hi    = b_hi;
            byte_valid = b_valid;
            mem_hl     = b_mem;
            sp_sub     = 1'b0;
        end
    end

    // Cross-module relations on the top outputs
    always_comb begin
        if (!$isunknown({opcode, field_pos, pair_mode, pair3_sp})) begin
            assert_sp_only_top_R7: assert (!sp_sub || (pair_mode && pair_sel == PAIR_TOP));
            assert_pair_no_byte_R6: assert (!pair_mode || (!byte_valid && !mem_hl));
            assert_byte_no_sp_R8: assert (pair_mode || !sp_sub);
            assert_acc_high_R4: assert (!(byte_valid && pair_sel == PAIR_TOP) || byte_hi);
        end
    end
endmodule

// File: tb/opfield_decoder_test.sv
module opfield_decoder_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] opcode = '0;
    logic       field_pos = 1'b0, pair_mode = 1'b0, pair3_sp = 1'b0;
    logic [1:0] pair_sel;
    logic       byte_hi, byte_valid, mem_hl, sp_sub;
    int         total = 0, bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opfield_decoder uut (
        .opcode(opcode), .field_pos(field_pos), .pair_mode(pair_mode),
        .pair3_sp(pair3_sp), .pair_sel(pair_sel), .byte_hi(byte_hi),
        .byte_valid(byte_valid), .mem_hl(mem_hl), .sp_sub(sp_sub)
    );

    // Expected {pair_sel, byte_hi, byte_valid, mem_hl, sp_sub} from the requirements
    function automatic logic [5:0] expect_of(input logic [2:0] c, input logic pm, input logic sp);
        if (pm)                return {c[2:1], 1'b0, 1'b0, 1'b0, (sp && c[2:1] == 2'b11)};
        else if (c == 3'b110)  return {2'b10, 1'b0, 1'b0, 1'b1, 1'b0};
        else if (c == 3'b111)  return {2'b11, 1'b1, 1'b1, 1'b0, 1'b0};
        else                   return {c[2:1], ~c[0], 1'b1, 1'b0, 1'b0};
    endfunction

    task automatic check(input string req, input logic [5:0] exp);
        logic [5:0] got;
        got = {pair_sel, byte_hi, byte_valid, mem_hl, sp_sub};
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s op=%h pos=%0b pm=%0b sp=%0b got=%b exp=%b",
                     req, opcode, field_pos, pair_mode, pair3_sp, got, exp);
        end
    endtask

    task automatic apply(input logic [7:0] op, input logic pos, input logic pm, input logic sp);
        @(negedge clk);
        opcode = op; field_pos = pos; pair_mode = pm; pair3_sp = sp;
        #1;
    endtask

    // Idle inputs after reset: code 000 is B
    task automatic t_reset_state();
        apply(8'h00, 1'b0, 1'b0, 1'b0);
        check("R3 reset-idle", 6'b00_1_1_0_0);
    endtask

    // R1: low field with junk in upper bits
    task automatic t_low_field();
        for (int c = 0; c < 8; c++) begin
            apply({5'b10110, c[2:0]}, 1'b0, 1'b0, 1'b0);
            check("R1 low", expect_of(c[2:0], 1'b0, 1'b0));
            apply({5'b01001, c[2:0]}, 1'b0, 1'b0, 1'b1);
            check("R1 low-junk R8", expect_of(c[2:0], 1'b0, 1'b0));
        end
    endtask

    // R2: middle field with junk in other bits
    task automatic t_mid_field();
        for (int c = 0; c < 8; c++) begin
            apply({2'b11, c[2:0], 3'b101}, 1'b1, 1'b0, 1'b0);
            check("R2 mid", expect_of(c[2:0], 1'b0, 1'b0));
            apply({2'b00, c[2:0], 3'b010}, 1'b1, 1'b0, 1'b1);
            check("R2 mid-junk R8", expect_of(c[2:0], 1'b0, 1'b0));
        end
    endtask

    // R3/R4/R5: named codes; move opcode 01 dst src through both fields
    task automatic t_named_and_move();
        apply(8'b01_111_000, 1'b1, 1'b0, 1'b0);
        check("R4 move dest A", 6'b11_1_1_0_0);
        apply(8'b01_111_000, 1'b0, 1'b0, 1'b0);
        check("R3 move src B", 6'b00_1_1_0_0);
        apply(8'b01_010_101, 1'b1, 1'b0, 1'b0);
        check("R3 move dest D", 6'b01_1_1_0_0);
        apply(8'b01_010_101, 1'b0, 1'b0, 1'b0);
        check("R3 move src L", 6'b10_0_1_0_0);
        apply(8'b10000_110, 1'b0, 1'b0, 1'b0);
        check("R5 add mem", 6'b10_0_0_1_0);
        apply(8'b00_110_101, 1'b1, 1'b0, 1'b1);
        check("R5 dec mem", 6'b10_0_0_1_0);
    endtask

    // R6/R7: pair mode, both SP settings, bit0 toggled
    task automatic t_pair_mode();
        for (int c = 0; c < 8; c++) begin
            for (int s = 0; s < 2; s++) begin
                apply({2'b00, c[2:0], 3'b011}, 1'b1, 1'b1, s[0]);
                check("R6 R7 pair", expect_of(c[2:0], 1'b1, s[0]));
            end
        end
        apply(8'b00_11_0_011, 1'b1, 1'b1, 1'b1);
        check("R7 sp", 6'b11_0_0_0_1);
        apply(8'b00_11_0_011, 1'b1, 1'b1, 1'b0);
        check("R7 af", 6'b11_0_0_0_0);
        apply(8'b00000_110, 1'b0, 1'b1, 1'b0);
        check("R6 110 in pair", 6'b11_0_0_0_0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_low_field();
        t_mid_field();
        t_named_and_move();
        t_pair_mode();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule